// File: doc/BRIEF.md
# Serial Clock Divisor Search Engine

This block picks the two divider settings of a synchronous serial port's bit clock. It is given the frequency of the clock that feeds the divider and the bit rate a client asks for. The request is first clamped into an allowed band. The engine then walks candidate pairs of an even prescaler and a rate field. It returns the first pair whose divided frequency, computed with integer truncation, is not above the clamped request. If no pair meets that test, it raises an error instead.

The divided frequency is `src / (prescale * (field + 1))`. The prescaler is the outer loop. It takes the even values from 2 up to the largest even value not above `PS_MAX`. The rate field is the inner loop and runs from 0 to `FLD_MAX`. With the default parameters (254 and 255), the allowed band is normally set from `src / (254*256)` up to `src / 2`. The band limits are inputs, so the integration decides them.

The engine tests one candidate per clock cycle and uses no divider. A search starts with a one-cycle strobe and ends with a one-cycle done pulse. The chosen pair is held on the outputs until the next search that succeeds.

Top module: `clkdiv_search`

## Requirements
- R1: After reset, busy, done and error are low and the prescale and field outputs are zero.
- R2: The request is clamped before the search. A request below the low limit becomes the low limit, and one above the high limit becomes the high limit. When the low limit exceeds the high limit, the high limit is used.
- R3: A candidate qualifies when `floor(src / (prescale * (field + 1)))` is at or below the clamped request, with the quotient truncated exactly as integer division truncates it.
- R4: Candidates are visited in a fixed order: even prescale from 2 upward is the outer loop, and field from 0 upward is the inner loop. The first qualifying candidate is returned, with an even prescale of at least 2.
- R5: One candidate is examined per cycle. Number the candidates from 0 in visiting order. If the search ends on candidate k, done is high in the (k+1)-th cycle after the clock edge that samples start.
- R6: Busy is high from the cycle after the accepted start until the search ends. It is low in the cycle where done is high, and done is high for exactly one cycle.
- R7: A start strobe that arrives while busy is ignored. The running search keeps its request and its timing.
- R8: If no candidate qualifies, done rises with error high after the last candidate, and the prescale and field outputs keep their previous values. A later successful search clears error.
- R9: The prescale and field outputs change only in a cycle where done is high; they are held at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Search strobe, sampled while idle |
| src_hz_i | input | FREQ_W | Frequency of the clock that feeds the divider |
| req_hz_i | input | FREQ_W | Requested serial bit rate |
| lo_hz_i | input | FREQ_W | Lowest allowed rate (clamp floor) |
| hi_hz_i | input | FREQ_W | Highest allowed rate (clamp ceiling) |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse when a search ends |
| err_o | output | 1 | Last search found no qualifying pair |
| prescale_o | output | PS_W | Chosen even prescaler |
| field_o | output | FLD_W | Chosen rate field |

## Verification
Busy is due one edge after the start strobe is sampled. Done, error and the result are due k+1 edges after that same strobe, where k is the index of the deciding candidate in visiting order. The bench computes k with its own truncating-division model. It counts falling-edge samples from the start edge and compares the count with k+1, so a result that arrives early or late fails even when its value is right. The bench runs a reduced configuration (prescale up to 10, field up to 7). This keeps every search within 40 candidates and lets a dense sweep of requests run against several source frequencies.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned CDS_WIDE = 64;

  typedef logic [CDS_WIDE-1:0] wide_t;

  typedef enum logic { CDS_IDLE = 1'b0, CDS_RUN = 1'b1 } cds_state_e;

  // Bound the request: floor first, then ceiling, so the ceiling wins
  // when the two limits cross.
  function automatic wide_t clamp_rate(wide_t v, wide_t lo, wide_t hi);
    wide_t t;
    t = (v < lo) ? lo : v;
    return (t > hi) ? hi : t;
  endfunction

  // floor(src / d) <= r  holds exactly when  src < (r + 1) * d.
  function automatic logic cand_meets(wide_t src, wide_t rate, wide_t ps, wide_t fld);
    wide_t lim;
    lim = (rate + wide_t'(1)) * ps * (fld + wide_t'(1));
    return src < lim;
  endfunction

endpackage

// File: rtl/cds_clamp.sv
module cds_clamp
  import clkdiv_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] rate_o
);

  wide_t bounded;

  always_comb begin
    bounded = clamp_rate(wide_t'(req_i), wide_t'(lo_i), wide_t'(hi_i));
    rate_o  = W'(bounded);
  end

endmodule

// File: rtl/cds_cursor.sv
module cds_cursor #(
  parameter int unsigned PS_MAX  = 254,
  parameter int unsigned FLD_MAX = 255,
  localparam int unsigned PS_W    = $clog2(PS_MAX + 1),
  localparam int unsigned FLD_W   = $clog2(FLD_MAX + 1),
  localparam int unsigned PS_LAST = PS_MAX - (PS_MAX % 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [PS_W-1:0]  ps_o,
  output logic [FLD_W-1:0] fld_o,
  output logic             last_o
);

  logic fld_wrap;

  assign fld_wrap = (fld_o == FLD_W'(FLD_MAX));
  assign last_o   = fld_wrap && (ps_o == PS_W'(PS_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_o  <= PS_W'(2);
      fld_o <= '0;
    end else if (load_i) begin
      ps_o  <= PS_W'(2);
      fld_o <= '0;
    end else if (step_i) begin
      if (fld_wrap) begin
        fld_o <= '0;
        ps_o  <= ps_o + PS_W'(2);
      end else begin
        fld_o <= fld_o + FLD_W'(1);
      end
    end
  end

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !load_i |=> ((fld_o == $past(fld_o) + FLD_W'(1)) && (ps_o == $past(ps_o))) ||
                          ((fld_o == '0) && (ps_o == $past(ps_o) + PS_W'(2)))); // R4

  AST_LOAD_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ps_o == PS_W'(2)) && (fld_o == '0)); // R4

endmodule

// File: rtl/cds_judge.sv
module cds_judge
  import clkdiv_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned PS_W  = 8,
  parameter int unsigned FLD_W = 8
) (
  input  logic [W-1:0]     src_i,
  input  logic [W-1:0]     rate_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [FLD_W-1:0] fld_i,
  output logic             hit_o
);

  always_comb begin
    hit_o = cand_meets(wide_t'(src_i), wide_t'(rate_i), wide_t'(ps_i), wide_t'(fld_i));
  end

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
  import clkdiv_pkg::*;
#(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned PS_MAX  = 254,
  parameter int unsigned FLD_MAX = 255,
  localparam int unsigned PS_W   = $clog2(PS_MAX + 1),
  localparam int unsigned FLD_W  = $clog2(FLD_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] src_hz_i,
  input  logic [FREQ_W-1:0] req_hz_i,
  input  logic [FREQ_W-1:0] lo_hz_i,
  input  logic [FREQ_W-1:0] hi_hz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [PS_W-1:0]   prescale_o,
  output logic [FLD_W-1:0]  field_o
);

  cds_state_e        state_q;
  logic [FREQ_W-1:0] src_q;
  logic [FREQ_W-1:0] rate_q;
  logic [FREQ_W-1:0] rate_bounded;
  logic [PS_W-1:0]   cur_ps;
  logic [FLD_W-1:0]  cur_fld;
  logic              cur_last;
  logic              cur_hit;

  // Named events for the assertions and the cursor.
  logic accept_w;
  logic running_w;
  logic finish_ok_w;
  logic finish_bad_w;
  logic advance_w;

  assign running_w    = (state_q == CDS_RUN);
  assign accept_w     = start_i && !running_w;
  assign finish_ok_w  = running_w && cur_hit;
  assign finish_bad_w = running_w && !cur_hit && cur_last;
  assign advance_w    = running_w && !cur_hit && !cur_last;
  assign busy_o       = running_w;

  cds_clamp #(.W(FREQ_W)) u_clamp (
    .req_i  (req_hz_i),
    .lo_i   (lo_hz_i),
    .hi_i   (hi_hz_i),
    .rate_o (rate_bounded)
  );

  cds_cursor #(.PS_MAX(PS_MAX), .FLD_MAX(FLD_MAX)) u_cursor (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_w),
    .step_i (advance_w),
    .ps_o   (cur_ps),
    .fld_o  (cur_fld),
    .last_o (cur_last)
  );

  cds_judge #(.W(FREQ_W), .PS_W(PS_W), .FLD_W(FLD_W)) u_judge (
    .src_i  (src_q),
    .rate_i (rate_q),
    .ps_i   (cur_ps),
    .fld_i  (cur_fld),
    .hit_o  (cur_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CDS_IDLE;
      src_q      <= '0;
      rate_q     <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      prescale_o <= '0;
      field_o    <= '0;
    end else begin
      done_o <= finish_ok_w || finish_bad_w;
      if (accept_w) begin
        state_q <= CDS_RUN;
        src_q   <= src_hz_i;
        rate_q  <= rate_bounded;
      end
      if (finish_ok_w || finish_bad_w) begin
        state_q <= CDS_IDLE;
      end
      if (finish_ok_w) begin
        prescale_o <= cur_ps;
        field_o    <= cur_fld;
        err_o      <= 1'b0;
      end else if (finish_bad_w) begin
        err_o <= 1'b1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R6

  AST_NOT_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(rate_q) && $stable(src_q)); // R7

  AST_CLAMP_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && (lo_hz_i <= hi_hz_i) |=> (rate_q >= $past(lo_hz_i)) && (rate_q <= $past(hi_hz_i))); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(prescale_o) && $stable(field_o)); // R9

  AST_ERR_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && err_o |-> $stable(prescale_o) && $stable(field_o)); // R8

  AST_EVEN_PRESCALE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !err_o |-> !prescale_o[0] && (prescale_o >= PS_W'(2))); // R4

endmodule

// File: tb/clkdiv_search_test.sv
`timescale 1ns/1ps
module clkdiv_search_test;

  localparam int FW   = 16;
  localparam int PSM  = 10;
  localparam int FLM  = 7;
  localparam int PSW  = $clog2(PSM + 1);
  localparam int FLW  = $clog2(FLM + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [FW-1:0]  src_hz = '0;
  logic [FW-1:0]  req_hz = '0;
  logic [FW-1:0]  lo_hz = '0;
  logic [FW-1:0]  hi_hz = '0;
  logic           busy;
  logic           done;
  logic           err;
  logic [PSW-1:0] presc;
  logic [FLW-1:0] fld;

  int n_chk = 0;
  int n_bad = 0;
  int last_p = 0;
  int last_f = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  clkdiv_search #(.FREQ_W(FW), .PS_MAX(PSM), .FLD_MAX(FLM)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .src_hz_i   (src_hz),
    .req_hz_i   (req_hz),
    .lo_hz_i    (lo_hz),
    .hi_hz_i    (hi_hz),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err),
    .prescale_o (presc),
    .field_o    (fld)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One search. poke: raise start again three cycles into the run (R7).
  task automatic run(input int srcv, input int reqv, input int lov, input int hiv,
                     input bit poke, input string tag);
    int r, k, idx, ep, ef, c;
    bit found;
    r = (reqv < lov) ? lov : reqv;
    r = (r > hiv) ? hiv : r;
    found = 1'b0; idx = 0; k = 0; ep = last_p; ef = last_f;
    for (int p = 2; p <= PSM; p += 2) begin
      for (int f = 0; f <= FLM; f++) begin
        if (!found && (srcv / (p * (f + 1)) <= r)) begin
          found = 1'b1; k = idx; ep = p; ef = f;
        end
        idx++;
      end
    end
    if (!found) k = idx - 1;
    @(negedge clk);
    start = 1'b1; src_hz = FW'(srcv); req_hz = FW'(reqv); lo_hz = FW'(lov); hi_hz = FW'(hiv);
    @(negedge clk);
    start = 1'b0;
    c = 0;
    chk("R6", "busy after start", busy, 1);
    while (!done && c < 500) begin
      if (poke && c == 3) begin
        start = 1'b1; req_hz = FW'(hiv); src_hz = FW'(srcv + 7);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      c++;
    end
    start = 1'b0;
    chk({tag, "/R5"}, "done cycle", c, k + 1);
    chk({tag, "/R8"}, "error flag", err, found ? 0 : 1);
    chk({tag, "/R3"}, "prescale", presc, ep);
    chk({tag, "/R4"}, "field", fld, ef);
    chk("R6", "busy low at done", busy, 0);
    @(negedge clk);
    chk("R6", "done one cycle", done, 0);
    last_p = ep; last_f = ef;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int srcs [3];
    srcs[0] = 1000; srcs[1] = 777; srcs[2] = 4095;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "prescale", presc, 0);
    chk("R1", "field", fld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep requests across and beyond the band for several sources (R2..R6)
    foreach (srcs[i]) begin
      int lo, hi, stp;
      lo = srcs[i] / (PSM * (FLM + 1));
      hi = srcs[i] / 2;
      stp = (hi + 10) / 120 + 1;
      for (int q = 0; q <= hi + 10; q += stp) run(srcs[i], q, lo, hi, 1'b0, "R4");
      run(srcs[i], hi + 500, lo, hi, 1'b0, "R2");
      run(srcs[i], 0, lo, hi, 1'b0, "R2");
    end

    // Crossed limits: ceiling wins (R2)
    run(1000, 200, 300, 100, 1'b0, "R2");

    // Truncation edge: 1000/(2*4)=125 exactly, 1000/(2*3)=166 (R3)
    run(1000, 125, 0, 500, 1'b0, "R3");
    run(1000, 124, 0, 500, 1'b0, "R3");
    run(1000, 166, 0, 500, 1'b0, "R3");

    // Known result, then an unreachable request: error, result kept (R8)
    run(1000, 250, 0, 500, 1'b0, "R8");
    run(1000, 5, 0, 500, 1'b0, "R8");
    chk("R8", "prescale kept", presc, 2);
    chk("R8", "field kept", fld, 1);
    run(1000, 0, 0, 500, 1'b0, "R8");
    run(1000, 300, 0, 500, 1'b0, "R8");
    chk("R8", "error cleared", err, 0);

    // Start during a long search is ignored (R7)
    run(1000, 13, 0, 500, 1'b1, "R7");

    // Outputs hold between completions (R9)
    repeat (6) @(negedge clk);
    chk("R9", "prescale held", presc, last_p);
    chk("R9", "field held", fld, last_f);
    chk("R9", "no done while idle", done, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule